// File: doc/BRIEF.md
# Bridge Control Register File

This block is the 4 KB control register space of a PCIe host bridge. Requests arrive on a simple port with a byte address, a write flag, an access size in bytes and 64-bit write data. Each request gets one response in the next cycle. The response carries the read data and an error flag.

Nearly every location is a 64-bit register. These registers take only 8-byte accesses on 8-byte boundaries. One 4-byte window is the exception: it passes configuration reads and writes to the target selected by the configuration address register. The window takes 1, 2 or 4 byte accesses. Because the window's data is little-endian inside a big-endian map, write data is byte-swapped before it goes out and read data is swapped on the way back.

Several registers have side effects instead of plain storage:
- AND and OR aliases modify an error accumulator and its mask.
- A lock register returns its old value on a read and sets its lock bit.
- A DMA quiesce register clears itself when its auto-reset bit is written.
- A write-zero register always stores zero.
- An upper-address register keeps only its top bits.
- The version register and the DMA read-sync register read fixed values.
- A one-cycle strobe marks any write that changes an address-window geometry register.

Top module: `brg_ctl_regs`

## Requirements
- R1: An access outside the configuration window must be 8 bytes wide and 8-byte aligned. Any other access sets `rsp_err` and stores nothing. If it is a read, it returns all-ones.
- R2: The configuration window covers byte offsets 0x100 to 0x103. It accepts size 1 at any offset, size 2 at an even offset and size 4 at offset 0x100. Any other size or alignment there sets `rsp_err`, nothing is forwarded, and a read returns all-ones.
- R3: The configuration address register is at 0x000. Bit 63 enables configuration access, bits 59:52 give `cfg_bus` and bits 51:44 give `cfg_devfn`. The target offset is bits 43:34 followed by two zero bits, ORed with the low two bits of the access address.
- R4: Window writes forward the low `size` bytes of write data in reversed byte order on `cfg_wr_data`, with `cfg_wr` pulsing one cycle after the request. Window reads return the low `size` bytes of `cfg_rdata` in reversed byte order, zero-extended.
- R5: If the enable bit is clear, or the target offset is at or above `cfg_limit`, a window write raises no `cfg_wr` and a window read returns all-ones. Neither case is an error.
- R6: Writes to 0x048 and 0x050 AND and OR the data into the accumulator at 0x040. Writes to 0x060 and 0x068 do the same for the mask at 0x058. The four alias addresses store nothing and read zero.
- R7: A write to the write-zero register at 0x070 stores zero.
- R8: In the quiesce register at 0x028, a write with bit 62 (auto-reset) set stores zero. Any other write keeps only bit 63 (quiesce).
- R9: The upper-address register at 0x020 keeps only bits 63:50 of written data.
- R10: A read of the lock register at 0x078 returns its contents before the read, and then sets bit 0.
- R11: The version register at 0x080 reads the parameter `VERSION_VAL`. The read-sync register at 0x088 reads only bit 63 set. Writes to either have no effect.
- R12: A write to window base 0x008, window mask 0x010, window start 0x018 or upper address 0x020 pulses `geo_chg` for one cycle in the response cycle, but only if the stored value changes.
- R13: An aligned 8-byte access to an unmapped offset is not an error. It stores nothing and reads zero.
- R14: Every request gives exactly one `rsp_valid` pulse in the next cycle. After reset every stored register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KB space |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_wdata | input | 64 | Write data, right-aligned for narrow accesses |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Size or alignment error |
| rsp_rdata | output | 64 | Read data |
| geo_chg | output | 1 | Window geometry changed strobe |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device-function |
| cfg_off | output | 12 | Target register offset for the current request |
| cfg_limit | input | 13 | Configuration space size of the selected target |
| cfg_rdata | input | 32 | Target read data for `cfg_off`, same cycle |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_wr_off | output | 12 | Offset of the forwarded write |
| cfg_wr_size | output | 4 | Size of the forwarded write in bytes |
| cfg_wr_data | output | 32 | Byte-swapped write data |

## Verification
The assertions assume that `req_valid` is low throughout reset. They also assume that the target drives `cfg_rdata` as a same-cycle function of `cfg_bus`, `cfg_devfn` and `cfg_off`. The bench's target model computes read data directly from those three outputs. The bench holds requests idle during reset and drives new stimulus only on falling edges, which keeps both assumptions true. Random offsets, sizes and configuration address values cover enabled and disabled access, both `cfg_limit` values and every window alignment.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int AW    = 12;
  localparam int DW    = 64;
  localparam int CW    = 32;

  localparam logic [AW-1:0] A_CFGADDR  = 12'h000;
  localparam logic [AW-1:0] A_WBASE    = 12'h008;
  localparam logic [AW-1:0] A_WMASK    = 12'h010;
  localparam logic [AW-1:0] A_WSTART   = 12'h018;
  localparam logic [AW-1:0] A_UPPER    = 12'h020;
  localparam logic [AW-1:0] A_QUIES    = 12'h028;
  localparam logic [AW-1:0] A_ACC      = 12'h040;
  localparam logic [AW-1:0] A_ACC_AND  = 12'h048;
  localparam logic [AW-1:0] A_ACC_OR   = 12'h050;
  localparam logic [AW-1:0] A_EMSK     = 12'h058;
  localparam logic [AW-1:0] A_EMSK_AND = 12'h060;
  localparam logic [AW-1:0] A_EMSK_OR  = 12'h068;
  localparam logic [AW-1:0] A_WZERO    = 12'h070;
  localparam logic [AW-1:0] A_LOCK     = 12'h078;
  localparam logic [AW-1:0] A_VER      = 12'h080;
  localparam logic [AW-1:0] A_SYNC     = 12'h088;
  localparam logic [AW-1:0] A_CFGDATA  = 12'h100;

  localparam logic [DW-1:0] UPPER_KEEP = 64'hfffc_0000_0000_0000;
  localparam int QUIES_BIT   = 63;
  localparam int AUTORST_BIT = 62;
  localparam int LOCK_BIT    = 0;
  localparam int SYNC_BIT    = 63;
  localparam int CFG_EN_BIT  = 63;

  // reverse the low sz bytes, zero the rest
  function automatic logic [CW-1:0] swap_bytes(input logic [CW-1:0] d,
                                               input logic [3:0] sz);
    case (sz)
      4'd1:    return {24'h0, d[7:0]};
      4'd2:    return {16'h0, d[7:0], d[15:8]};
      4'd4:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/brg_acc_decode.sv
module brg_acc_decode
  import brg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [3:0]    size,
  output logic          is_win,
  output logic          ok
);
  logic win_ok, reg_ok;

  always_comb begin
    is_win = (addr[AW-1:2] == A_CFGDATA[AW-1:2]);
    win_ok = is_win && ((size == 4'd1) ||
                        (size == 4'd2 && !addr[0]) ||
                        (size == 4'd4 && addr[1:0] == 2'b00));
    reg_ok = !is_win && (size == 4'd8) && (addr[2:0] == 3'b000);
    ok     = win_ok || reg_ok;
  end
endmodule

// File: rtl/brg_cfg_port.sv
module brg_cfg_port
  import brg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] caddr,
  input  logic          fire_wr,
  input  logic [1:0]    byte_lo,
  input  logic [3:0]    size,
  input  logic [CW-1:0] wdata,
  input  logic [12:0]   cfg_limit,
  input  logic [CW-1:0] cfg_rdata,
  output logic [7:0]    cfg_bus,
  output logic [7:0]    cfg_devfn,
  output logic [11:0]   cfg_off,
  output logic [DW-1:0] rd_data,
  output logic          cfg_wr,
  output logic [11:0]   cfg_wr_off,
  output logic [3:0]    cfg_wr_size,
  output logic [CW-1:0] cfg_wr_data
);
  logic live;

  always_comb begin
    cfg_bus   = caddr[59:52];
    cfg_devfn = caddr[51:44];
    cfg_off   = {caddr[43:34], byte_lo};
    live      = caddr[CFG_EN_BIT] && ({1'b0, cfg_off} < cfg_limit);
    rd_data   = live ? {32'h0, swap_bytes(cfg_rdata, size)} : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_wr      <= 1'b0;
      cfg_wr_off  <= '0;
      cfg_wr_size <= '0;
      cfg_wr_data <= '0;
    end else begin
      cfg_wr <= fire_wr && live;
      if (fire_wr && live) begin
        cfg_wr_off  <= cfg_off;
        cfg_wr_size <= size;
        cfg_wr_data <= swap_bytes(wdata, size);
      end
    end
  end
endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
  import brg_pkg::*;
#(
  parameter logic [63:0] VERSION_VAL = 64'h0000_0031_0000_0002
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [11:0]   req_addr,
  input  logic [3:0]    req_size,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [63:0]   rsp_rdata,
  output logic          geo_chg,
  output logic [7:0]    cfg_bus,
  output logic [7:0]    cfg_devfn,
  output logic [11:0]   cfg_off,
  input  logic [12:0]   cfg_limit,
  input  logic [31:0]   cfg_rdata,
  output logic          cfg_wr,
  output logic [11:0]   cfg_wr_off,
  output logic [3:0]    cfg_wr_size,
  output logic [31:0]   cfg_wr_data
);
  logic          is_win, acc_ok;
  logic          wr_go, rd_go, win_wr;
  logic [DW-1:0] caddr_q, wbase_q, wmask_q, wstart_q, upper_q, quies_q;
  logic [DW-1:0] acc_q, emsk_q, wzero_q, lock_q;
  logic [DW-1:0] reg_rd, win_rd, upper_new, quies_new;

  brg_acc_decode u_dec (
    .addr(req_addr), .size(req_size), .is_win(is_win), .ok(acc_ok)
  );

  assign wr_go  = req_valid && req_write && acc_ok && !is_win;
  assign rd_go  = req_valid && !req_write && acc_ok && !is_win;
  assign win_wr = req_valid && req_write && acc_ok && is_win;

  brg_cfg_port u_cfg (
    .clk(clk), .rst(rst), .caddr(caddr_q), .fire_wr(win_wr),
    .byte_lo(req_addr[1:0]), .size(req_size), .wdata(req_wdata[31:0]),
    .cfg_limit(cfg_limit), .cfg_rdata(cfg_rdata),
    .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_off(cfg_off),
    .rd_data(win_rd), .cfg_wr(cfg_wr), .cfg_wr_off(cfg_wr_off),
    .cfg_wr_size(cfg_wr_size), .cfg_wr_data(cfg_wr_data)
  );

  always_comb begin
    upper_new = req_wdata & UPPER_KEEP;
    quies_new = '0;
    if (!req_wdata[AUTORST_BIT]) quies_new[QUIES_BIT] = req_wdata[QUIES_BIT];
  end

  always_comb begin
    case (req_addr)
      A_CFGADDR: reg_rd = caddr_q;
      A_WBASE:   reg_rd = wbase_q;
      A_WMASK:   reg_rd = wmask_q;
      A_WSTART:  reg_rd = wstart_q;
      A_UPPER:   reg_rd = upper_q;
      A_QUIES:   reg_rd = quies_q;
      A_ACC:     reg_rd = acc_q;
      A_EMSK:    reg_rd = emsk_q;
      A_WZERO:   reg_rd = wzero_q;
      A_LOCK:    reg_rd = lock_q;
      A_VER:     reg_rd = VERSION_VAL;
      A_SYNC:    reg_rd = 64'h1 << SYNC_BIT;
      default:   reg_rd = '0;
    endcase
  end

  // register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      caddr_q <= '0; wbase_q <= '0; wmask_q <= '0; wstart_q <= '0;
      upper_q <= '0; quies_q <= '0; acc_q   <= '0; emsk_q   <= '0;
      wzero_q <= '0; lock_q  <= '0; geo_chg <= 1'b0;
    end else begin
      geo_chg <= 1'b0;
      if (wr_go) begin
        case (req_addr)
          A_CFGADDR:  caddr_q <= req_wdata;
          A_WBASE:    begin wbase_q  <= req_wdata; geo_chg <= (req_wdata != wbase_q);  end
          A_WMASK:    begin wmask_q  <= req_wdata; geo_chg <= (req_wdata != wmask_q);  end
          A_WSTART:   begin wstart_q <= req_wdata; geo_chg <= (req_wdata != wstart_q); end
          A_UPPER:    begin upper_q  <= upper_new; geo_chg <= (upper_new != upper_q);  end
          A_QUIES:    quies_q <= quies_new;
          A_ACC:      acc_q   <= req_wdata;
          A_ACC_AND:  acc_q   <= acc_q & req_wdata;
          A_ACC_OR:   acc_q   <= acc_q | req_wdata;
          A_EMSK:     emsk_q  <= req_wdata;
          A_EMSK_AND: emsk_q  <= emsk_q & req_wdata;
          A_EMSK_OR:  emsk_q  <= emsk_q | req_wdata;
          A_WZERO:    wzero_q <= '0;
          A_LOCK:     lock_q  <= req_wdata;
          default:    ;
        endcase
      end
      if (rd_go && req_addr == A_LOCK) lock_q[LOCK_BIT] <= 1'b1;
    end
  end

  // response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      if (req_valid) begin
        if (!acc_ok)        rsp_rdata <= '1;
        else if (req_write) rsp_rdata <= '0;
        else if (is_win)    rsp_rdata <= win_rd;
        else                rsp_rdata <= reg_rd;
      end
    end
  end
endmodule

// File: rtl/brg_ctl_regs_chk.sv
module brg_ctl_regs_chk #(
  parameter logic [63:0] VERSION_VAL = 64'h0
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [3:0]  req_size,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata,
  input logic        geo_chg,
  input logic        cfg_wr
);
  p_resp_next_r14: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_err_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid));

  p_err_ones_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_err && !$past(req_write)) |-> (rsp_rdata == 64'hffff_ffff_ffff_ffff));

  p_cfgwr_src_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> $past(req_valid && req_write && req_addr[11:2] == 10'h040));

  p_geo_src_r12: assert property (@(posedge clk) disable iff (rst)
    geo_chg |-> $past(req_valid && req_write && req_size == 4'd8));

  p_version_r11: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !req_write && req_addr == 12'h080 && req_size == 4'd8)
      |-> (rsp_rdata == VERSION_VAL));

  p_wzero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !req_write && req_addr == 12'h070 && req_size == 4'd8)
      |-> (rsp_rdata == 64'h0));
endmodule

bind brg_ctl_regs brg_ctl_regs_chk #(.VERSION_VAL(VERSION_VAL)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .geo_chg(geo_chg), .cfg_wr(cfg_wr)
);

// File: tb/brg_ctl_regs_bench.sv
module brg_ctl_regs_bench;
  localparam logic [63:0] VER = 64'h0000_0031_0000_0002;

  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [3:0]  req_size = 0;
  logic [63:0] req_wdata = 0;
  logic        rsp_valid, rsp_err, geo_chg, cfg_wr;
  logic [63:0] rsp_rdata;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [11:0] cfg_off, cfg_wr_off;
  logic [12:0] cfg_limit = 13'd256;
  logic [31:0] cfg_rdata, cfg_wr_data;
  logic [3:0]  cfg_wr_size;

  int unsigned n_run = 0, n_fail = 0;
  bit done = 0;

  // shadow model
  logic [63:0] m_caddr, m_base, m_mask, m_start, m_upper, m_quies;
  logic [63:0] m_acc, m_emsk, m_wzero, m_lock;

  always #5 clk = ~clk;

  // target model: data built from the selection
  assign cfg_rdata = {cfg_bus, cfg_devfn, 4'h0, cfg_off};

  brg_ctl_regs #(.VERSION_VAL(VER)) u_brg_ctl_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .geo_chg(geo_chg), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_off(cfg_off), .cfg_limit(cfg_limit), .cfg_rdata(cfg_rdata),
    .cfg_wr(cfg_wr), .cfg_wr_off(cfg_wr_off), .cfg_wr_size(cfg_wr_size),
    .cfg_wr_data(cfg_wr_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] d, input logic [3:0] sz);
    logic [31:0] r = 0;
    for (int i = 0; i < 4; i++)
      if (i < int'(sz)) r[8*i +: 8] = d[8*(int'(sz)-1-i) +: 8];
    return r;
  endfunction

  function automatic bit in_win(input logic [11:0] a);
    return a[11:2] == 10'h040;
  endfunction

  function automatic bit acc_legal(input logic [11:0] a, input logic [3:0] s);
    if (in_win(a)) return (s == 1) || (s == 2 && !a[0]) || (s == 4 && a[1:0] == 0);
    return s == 8 && a[2:0] == 0;
  endfunction

  function automatic logic [63:0] reg_val(input logic [11:0] a);
    case (a)
      12'h000: return m_caddr;  12'h008: return m_base;
      12'h010: return m_mask;   12'h018: return m_start;
      12'h020: return m_upper;  12'h028: return m_quies;
      12'h040: return m_acc;    12'h058: return m_emsk;
      12'h070: return m_wzero;  12'h078: return m_lock;
      12'h080: return VER;      12'h088: return 64'h8000_0000_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] s,
                        input logic [63:0] d);
    bit legal = acc_legal(a, s);
    bit win = in_win(a);
    logic [11:0] toff = {m_caddr[43:34], a[1:0]};
    bit live = m_caddr[63] && ({1'b0, toff} < cfg_limit);
    logic [63:0] exp_rd = 0;
    bit exp_geo = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
    if (!legal) exp_rd = '1;
    else if (!wr && win) exp_rd = live ? {32'h0, rev({cfg_bus_exp(), m_caddr[51:44], 4'h0, toff}, s)} : '1;
    else if (!wr) exp_rd = reg_val(a);
    @(negedge clk);
    req_valid = 0;
    check("R14 rsp_valid", {63'h0, rsp_valid}, 64'h1);
    check(legal ? "R13 rsp_err" : (win ? "R2 rsp_err" : "R1 rsp_err"),
          {63'h0, rsp_err}, {63'h0, !legal});
    if (!wr) check(!legal ? "R1 ones" : win ? "R4/R5 window read" : "R6-R11 read",
                   rsp_rdata, exp_rd);
    check("R5 cfg_wr", {63'h0, cfg_wr}, {63'h0, wr && legal && win && live});
    if (wr && legal && win && live) begin
      check("R4 cfg_wr_data", {32'h0, cfg_wr_data}, {32'h0, rev(d[31:0], s)});
      check("R3 cfg_wr_off", {52'h0, cfg_wr_off}, {52'h0, toff});
      check("R3 cfg_bus", {48'h0, cfg_bus, cfg_devfn}, {48'h0, m_caddr[59:44]});
    end
    // update model
    if (legal && !wr && a == 12'h078) m_lock[0] = 1'b1;
    if (legal && wr && !win) begin
      case (a)
        12'h000: m_caddr = d;
        12'h008: begin exp_geo = d != m_base;  m_base = d;  end
        12'h010: begin exp_geo = d != m_mask;  m_mask = d;  end
        12'h018: begin exp_geo = d != m_start; m_start = d; end
        12'h020: begin exp_geo = (d & 64'hfffc_0000_0000_0000) != m_upper;
                       m_upper = d & 64'hfffc_0000_0000_0000; end
        12'h028: m_quies = d[62] ? 64'h0 : (d & 64'h8000_0000_0000_0000);
        12'h040: m_acc = d;
        12'h048: m_acc = m_acc & d;
        12'h050: m_acc = m_acc | d;
        12'h058: m_emsk = d;
        12'h060: m_emsk = m_emsk & d;
        12'h068: m_emsk = m_emsk | d;
        12'h070: m_wzero = 0;
        12'h078: m_lock = d;
        default: ;
      endcase
    end
    check("R12 geo_chg", {63'h0, geo_chg}, {63'h0, exp_geo});
  endtask

  function automatic logic [7:0] cfg_bus_exp();
    return m_caddr[59:52];
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [20];
    void'($urandom(32'd1234));
    {m_caddr, m_base, m_mask, m_start, m_upper} = '0;
    {m_quies, m_acc, m_emsk, m_wzero, m_lock} = '0;
    addrs = '{12'h000, 12'h008, 12'h010, 12'h018, 12'h020, 12'h028, 12'h040,
              12'h048, 12'h050, 12'h058, 12'h060, 12'h068, 12'h070, 12'h078,
              12'h080, 12'h088, 12'h0a0, 12'h0f8, 12'h100, 12'h100};
    repeat (3) @(negedge clk);
    rst = 0;
    // R14 reset state
    access(0, 12'h008, 8, 0);
    access(0, 12'h040, 8, 0);
    access(0, 12'h078, 8, 0);
    // R10 lock: second read sees bit set
    access(0, 12'h078, 8, 0);
    // R11 fixed reads ignore writes
    access(1, 12'h080, 8, 64'h1234);
    access(0, 12'h080, 8, 0);
    access(0, 12'h088, 8, 0);
    // R8 quiesce
    access(1, 12'h028, 8, 64'hffff_ffff_ffff_ffff);
    access(0, 12'h028, 8, 0);
    access(1, 12'h028, 8, 64'hbfff_0000_0000_0001);
    access(0, 12'h028, 8, 0);
    // R9 upper mask, R12 strobe then no strobe on same value
    access(1, 12'h020, 8, 64'hffff_ffff_ffff_ffff);
    access(1, 12'h020, 8, 64'hfffc_0000_0000_0000);
    access(0, 12'h020, 8, 0);
    // R6 aliases, R7 write-zero
    access(1, 12'h040, 8, 64'hff00_ff00_ff00_ff00);
    access(1, 12'h048, 8, 64'hf0f0_f0f0_f0f0_f0f0);
    access(1, 12'h050, 8, 64'h0000_0000_0000_000f);
    access(0, 12'h040, 8, 0);
    access(0, 12'h048, 8, 0);
    access(1, 12'h070, 8, 64'hdead_beef);
    access(0, 12'h070, 8, 0);
    // R1 misaligned / narrow
    access(1, 12'h044, 8, 64'h5);
    access(0, 12'h008, 4, 0);
    // R3 R4 R5 window: enabled, offset 0x040
    access(1, 12'h000, 8, 64'h8ab5_c040_0000_0000);
    access(1, 12'h100, 4, 64'h1122_3344);
    access(1, 12'h102, 2, 64'hbeef);
    access(0, 12'h101, 1, 0);
    access(0, 12'h100, 4, 0);
    access(0, 12'h101, 2, 0);          // R2 misaligned
    access(1, 12'h100, 8, 0);          // R2 wrong size
    // R5 beyond limit
    access(1, 12'h000, 8, 64'h8ab5_c200_0000_0000);
    access(1, 12'h100, 4, 64'h55);
    access(0, 12'h100, 4, 0);
    // R5 disabled
    access(1, 12'h000, 8, 64'h0ab5_c040_0000_0000);
    access(0, 12'h100, 4, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [3:0] s;
      logic [63:0] d;
      bit wr;
      if (i == 2000) cfg_limit = 13'd4096;
      a = addrs[$urandom_range(0, 19)];
      if (a == 12'h100) begin
        a = a + 12'($urandom_range(0, 3));
        s = 4'(1 << $urandom_range(0, 3));
      end else if ($urandom_range(0, 9) == 0) begin
        s = 4'(1 << $urandom_range(0, 2));
        a = a + 12'($urandom_range(0, 7));
      end else s = 8;
      wr = $urandom_range(0, 1) == 1;
      d = {$urandom, $urandom};
      if (a == 12'h000 && $urandom_range(0, 3) != 0) d[63] = 1'b1;
      if (($urandom_range(0, 3) == 0) && (a == 12'h008)) d = m_base;
      access(wr, a, s, d);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule